// File: doc/BRIEF.md
# Parity Serial Transmitter

This block turns one parallel data word into an asynchronous serial character. A write strobe loads the word, but only while the transmit enable input is high and no character is in flight. The block then drives its line output low for one start bit. It shifts out 7, 8 or 9 data bits, least significant bit first. One parity bit follows, odd or even by a control input, and then one high stop bit. Between characters the line rests high.

Bit timing comes from an external baud tick strobe, and each bit lasts sixteen ticks. A buffer-full flag rises as soon as a write is accepted. It drops at the end of the stop bit. At that same moment the block can raise a one-cycle completion pulse for an interrupt controller. A software register model can therefore poll the flag or take the interrupt.

Top module: `serial_frame_tx`

## Requirements
- R1: After synchronous reset the line output is 1, the buffer-full flag is 0 and the completion pulse is 0.
- R2: A write strobe sampled while tx_en is 1 and buf_full is 0 is accepted. In the next cycle buf_full is 1 and the line is 0, which is the start bit.
- R3: A write strobe sampled while tx_en is 0 is ignored: buf_full stays 0 and the line stays 1.
- R4: Every bit of a frame, the start bit included, holds the line for exactly 16 baud ticks, counted from the cycle after acceptance. A tick in the accepting cycle does not count.
- R5: Data bits are sent least significant bit first. The count follows len_sel: 0 gives 7 bits, 1 gives 8, 2 gives 9 and 3 gives 8. Word bits above the selected count are ignored.
- R6: The parity bit follows the last data bit and is computed over the selected data bits only. With par_odd=1 the data ones plus the parity bit make an odd total; with par_odd=0 they make an even total.
- R7: A single 1 stop bit ends the frame, and the line stays 1 until the next accepted write.
- R8: buf_full falls in the cycle after the stop bit's 16th tick. In that same cycle done_irq pulses high for one cycle if irq_en is 1, and stays low if irq_en is 0.
- R9: A write strobe while buf_full is 1 is ignored, and the frame in progress completes with its original bits.
- R10: Clearing tx_en during a frame does not cut it; the frame completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable; gates acceptance of writes |
| wr_stb | input | 1 | One-cycle write strobe for the data word |
| wr_data | input | DATA_W (9) | Data word to send |
| len_sel | input | 2 | Data length select (0:7, 1:8, 2:9, 3:8 bits) |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| irq_en | input | 1 | Enables the completion pulse |
| baud_tick | input | 1 | Baud strobe; 16 per bit |
| tx_line | output | 1 | Serial line output |
| buf_full | output | 1 | High from write acceptance until stop-bit end |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
A corrupted state, bit counter or tick counter shows on tx_line as a wrong bit at the next mid-bit sample. It also shows as a frame that ends early or late against its tick count. Either appears within one bit time, which is sixteen ticks. A stuck or mis-latched shift register appears as a data or parity mismatch inside the same frame. A fault in the busy logic shows up differently. A late-write fault either changes the bits of the running frame or raises buf_full on a disabled write, so it is visible in the next cycle. A fault in the completion logic shows as a missing, misplaced or unrequested done_irq at the end of a frame.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    localparam int unsigned SER_DATA_W    = 9;
    localparam int unsigned SER_TICKS_BIT = 16;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } tx_phase_t;

    // Number of data bits selected by the two-bit length code.
    function automatic logic [3:0] data_len(input logic [1:0] code);
        case (code)
            2'd0:    data_len = 4'd7;
            2'd2:    data_len = 4'd9;
            default: data_len = 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
    parameter int unsigned TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic baud_tick,
    output logic bit_end
);
    localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign bit_end = run && !clear && baud_tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            cnt_q <= '0;
        end else if (baud_tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tx_parity_gen.sv
module tx_parity_gen #(
    parameter int unsigned DATA_W = 9
) (
    input  logic [DATA_W-1:0] data,
    input  logic [3:0]        nbits,
    input  logic              odd,
    output logic [DATA_W-1:0] masked,
    output logic              par_bit
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign masked[i] = data[i] && (nbits > 4'(i));
    end

    assign par_bit = (^masked) ^ odd;
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
    import serial_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] load_data,
    input  logic [3:0]        load_len,
    input  logic              load_par,
    input  logic              bit_end,
    output logic              busy,
    output logic              line,
    output logic              stop_end
);
    tx_phase_t         phase_q;
    logic [DATA_W-1:0] shreg_q;
    logic [3:0]        left_q;
    logic              par_q;

    assign busy     = (phase_q != PH_IDLE);
    assign stop_end = (phase_q == PH_STOP) && bit_end;

    always_comb begin
        case (phase_q)
            PH_START:  line = 1'b0;
            PH_DATA:   line = shreg_q[0];
            PH_PARITY: line = par_q;
            default:   line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            shreg_q <= '0;
            left_q  <= '0;
            par_q   <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start) begin
                    phase_q <= PH_START;
                    shreg_q <= load_data;
                    left_q  <= load_len;
                    par_q   <= load_par;
                end
                PH_START: if (bit_end) phase_q <= PH_DATA;
                PH_DATA: if (bit_end) begin
                    shreg_q <= shreg_q >> 1;
                    left_q  <= left_q - 1'b1;
                    if (left_q == 4'd1) phase_q <= PH_PARITY;
                end
                PH_PARITY: if (bit_end) phase_q <= PH_STOP;
                PH_STOP:   if (bit_end) phase_q <= PH_IDLE;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import serial_tx_pkg::*;
#(
    parameter int unsigned DATA_W = SER_DATA_W,
    parameter int unsigned TICKS  = SER_TICKS_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        len_sel,
    input  logic              par_odd,
    input  logic              irq_en,
    input  logic              baud_tick,
    output logic              tx_line,
    output logic              buf_full,
    output logic              done_irq
);
    logic              busy, accept, bit_end, stop_end, par_bit;
    logic [3:0]        nbits;
    logic [DATA_W-1:0] masked;

    assign nbits  = data_len(len_sel);
    assign accept = wr_stb && tx_en && !busy;

    tx_parity_gen #(.DATA_W(DATA_W)) u_par (
        .data(wr_data), .nbits(nbits), .odd(par_odd),
        .masked(masked), .par_bit(par_bit)
    );

    tx_bit_timer #(.TICKS(TICKS)) u_tmr (
        .clk(clk), .rst(rst), .clear(accept), .run(busy),
        .baud_tick(baud_tick), .bit_end(bit_end)
    );

    tx_frame_seq #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst(rst), .start(accept),
        .load_data(masked), .load_len(nbits), .load_par(par_bit),
        .bit_end(bit_end), .busy(busy), .line(tx_line), .stop_end(stop_end)
    );

    assign buf_full = busy;

    always_ff @(posedge clk) begin
        if (rst) done_irq <= 1'b0;
        else     done_irq <= stop_end && irq_en;
    end
endmodule

// File: rtl/serial_frame_tx_chk.sv
module serial_frame_tx_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic wr_stb,
    input logic irq_en,
    input logic baud_tick,
    input logic tx_line,
    input logic buf_full,
    input logic done_irq
);
    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!buf_full && wr_stb && tx_en) |=> (buf_full && !tx_line));

    // R3
    disabled_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!buf_full && wr_stb && !tx_en) |=> !buf_full);

    // R7
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !buf_full |-> tx_line);

    // R4
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_full && $past(buf_full) && !$past(baud_tick)) |-> $stable(tx_line));

    // R8
    irq_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        done_irq |-> ($past(buf_full) && !buf_full && $past(irq_en)));

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_irq |=> !done_irq);
endmodule

bind serial_frame_tx serial_frame_tx_chk u_chk (
    .clk(clk), .rst(rst), .tx_en(tx_en), .wr_stb(wr_stb), .irq_en(irq_en),
    .baud_tick(baud_tick), .tx_line(tx_line), .buf_full(buf_full),
    .done_irq(done_irq)
);

// File: tb/test_serial_frame_tx.sv
module test_serial_frame_tx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0, wr_stb = 1'b0, par_odd = 1'b0, irq_en = 1'b0;
    logic       baud_tick = 1'b0;
    logic [8:0] wr_data = '0;
    logic [1:0] len_sel = '0;
    logic       tx_line, buf_full, done_irq;

    always #5 clk = ~clk;

    serial_frame_tx i_serial_frame_tx (
        .clk(clk), .rst(rst), .tx_en(tx_en), .wr_stb(wr_stb), .wr_data(wr_data),
        .len_sel(len_sel), .par_odd(par_odd), .irq_en(irq_en), .baud_tick(baud_tick),
        .tx_line(tx_line), .buf_full(buf_full), .done_irq(done_irq)
    );

    typedef struct {
        bit bits[12];
        int n;
        bit irq;
    } frame_t;

    frame_t exp_q[$];
    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: issue a write and queue the expected frame.
    task automatic send(input logic [8:0] d, input logic [1:0] ls, input bit odd, input bit ie);
        frame_t f;
        int nb, ones;
        while (buf_full) @(negedge clk);
        nb = (ls == 2'd0) ? 7 : (ls == 2'd2) ? 9 : 8;
        ones = 0;
        f.bits[0] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            f.bits[1+i] = d[i];
            ones += int'(d[i]);
        end
        f.bits[1+nb] = bit'(ones & 1) ^ odd;
        f.bits[2+nb] = 1'b1;
        f.n = nb + 3;
        f.irq = ie;
        exp_q.push_back(f);
        wr_data = d; len_sel = ls; par_odd = odd; irq_en = ie; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(buf_full === 1'b1, "R2 buf_full after write", int'(buf_full), 1);
        chk(tx_line === 1'b0, "R2 start bit", int'(tx_line), 0);
    endtask

    // Monitor plus tick source in one process.
    frame_t cur;
    bit     in_frame = 0;
    int     ticks = 0, bidx = 0, tdiv = 0;

    always @(negedge clk) begin
        if (rst) begin
            in_frame = 0;
            baud_tick = 1'b0;
            tdiv = 0;
        end else begin
            if (!in_frame) begin
                if (done_irq) chk(0, "R8 stray done_irq", 1, 0);
                if (tx_line === 1'b0) begin
                    if (exp_q.size() == 0) chk(0, "R3/R9 unexpected start", 0, 1);
                    else begin
                        cur = exp_q.pop_front();
                        in_frame = 1; ticks = 0; bidx = 0;
                    end
                end
            end else begin
                if (baud_tick) begin
                    ticks++;
                    if (ticks == 8) begin
                        if (bidx == 0)
                            chk(tx_line === cur.bits[0], "R2 start bit mid", int'(tx_line), int'(cur.bits[0]));
                        else if (bidx == cur.n - 1)
                            chk(tx_line === 1'b1, "R7 stop bit", int'(tx_line), 1);
                        else if (bidx == cur.n - 2)
                            chk(tx_line === cur.bits[bidx], "R6 parity bit", int'(tx_line), int'(cur.bits[bidx]));
                        else
                            chk(tx_line === cur.bits[bidx], "R5 data bit", int'(tx_line), int'(cur.bits[bidx]));
                    end
                end
                if (ticks == 16 && bidx == cur.n - 1) begin
                    in_frame = 0;
                    chk(buf_full === 1'b0, "R4 frame length / R8 buf_full clear", int'(buf_full), 0);
                    chk(done_irq === cur.irq, "R8 done_irq", int'(done_irq), int'(cur.irq));
                end else begin
                    if (done_irq) chk(0, "R8 done_irq mid-frame", 1, 0);
                    if (ticks == 16) begin
                        ticks = 0;
                        bidx++;
                        chk(buf_full === 1'b1, "R4 frame still busy", int'(buf_full), 1);
                    end
                end
            end
            tdiv = (tdiv + 1) % 4;
            baud_tick = (tdiv == 0);
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (buf_full || in_frame || exp_q.size() != 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(tx_line === 1'b1, "R1 line after reset", int'(tx_line), 1);
        chk(buf_full === 1'b0, "R1 buf_full after reset", int'(buf_full), 0);
        chk(done_irq === 1'b0, "R1 done_irq after reset", int'(done_irq), 0);

        // R3: write while disabled
        wr_data = 9'h0A5; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        repeat (100) @(negedge clk);
        chk(buf_full === 1'b0, "R3 buf_full stays low", int'(buf_full), 0);
        chk(tx_line === 1'b1, "R3 line stays high", int'(tx_line), 1);

        tx_en = 1'b1;
        send(9'h0A5, 2'd1, 1'b0, 1'b1);  wait_idle();   // R5 8 bits even
        send(9'h1FF, 2'd0, 1'b1, 1'b0);  wait_idle();   // R5 R6 7 bits, top ignored
        send(9'h155, 2'd2, 1'b1, 1'b1);  wait_idle();   // 9 bits odd
        send(9'h1F0, 2'd3, 1'b0, 1'b1);  wait_idle();   // code 3 = 8 bits
        send(9'h000, 2'd2, 1'b1, 1'b0);  wait_idle();   // all zeros odd

        // R9: late write is ignored
        send(9'h03C, 2'd1, 1'b1, 1'b1);
        repeat (150) @(negedge clk);
        wr_data = 9'h0FF; len_sel = 2'd2; par_odd = 1'b0; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(buf_full === 1'b1, "R9 busy after late write", int'(buf_full), 1);
        wait_idle();

        // R10: enable dropped mid-frame
        send(9'h0C3, 2'd1, 1'b0, 1'b1);
        repeat (200) @(negedge clk);
        tx_en = 1'b0;
        wait_idle();
        chk(tx_line === 1'b1, "R10 line idle after frame", int'(tx_line), 1);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule